// File: doc/BRIEF.md
# Peripheral Request to Channel Router

This block sits between the request lines of up to 75 peripherals and a bank of DMA channels. Each request input has a small map entry, written by software over a simple register port. The entry names a target channel and carries an enable flag. The router registers the raw inputs once. It ORs together every enabled input aimed at a channel and presents that channel's combined request level. It also watches each combined level for edges. A rising edge raises a one-cycle request-after-stop event and a held pending flag. A falling edge raises a one-cycle end-of-receive event and clears the pending flag.

The map entries live in two address windows. The first 64 entries take consecutive words from byte offset 0x100. The remaining entries take consecutive words from byte offset 0x1100. Three request-status words at 0xE0, 0xE4 and 0xE8 are decoded but hold nothing. A write that enables an entry aimed at a channel that does not exist is refused and flagged.

Top module: `req_router`

## Requirements
- R1: A synchronous active-high reset clears every map entry to disabled, channel zero, and clears every level, event, pending flag and the error output.
- R2: Entry n (n below 64) is at byte offset 0x100+4n, and entry n (64 to 74) is at 0x1100+4(n-64). Only word-aligned offsets decode. A write stores data bit 7 as the enable flag and bits [4:0] as the channel. A read returns those two fields in the same positions with every other bit zero, and raises reg_hit.
- R3: Offsets 0xE0, 0xE4 and 0xE8 raise reg_hit, always read as zero, and a write to them changes no entry.
- R4: An input whose entry is disabled has no effect on any channel level or event.
- R5: ch_req_lvl[c] is the OR of the inputs whose entries are enabled and aimed at channel c. The inputs are sampled at one clock edge and the map is taken as it stood before that edge. The result appears after the next edge.
- R6: When a channel's combined level goes from low to high, ch_ras_evt for that channel is high for exactly the cycle in which the new level is first shown.
- R7: When a channel's combined level goes from high to low, ch_eor_evt for that channel is high for exactly the cycle in which the low level is first shown.
- R8: ch_ras_pend for a channel is set by its rising edge and stays set until its falling edge clears it.
- R9: A map write with bit 7 set and a channel number not below NUM_CH (16 by default) is not stored. It drives map_err high for the one cycle after the write.
- R10: Any other offset, including a misaligned one inside a map window, drops reg_hit, reads zero, and a write there changes no entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | NUM_REQ | Raw peripheral request levels |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| reg_hit | output | 1 | reg_addr decodes to a map or status word |
| map_err | output | 1 | Refused map write, pulse one cycle after it |
| ch_req_lvl | output | NUM_CH | Combined request level per channel |
| ch_ras_evt | output | NUM_CH | Rising-edge event per channel |
| ch_eor_evt | output | NUM_CH | Falling-edge event per channel |
| ch_ras_pend | output | NUM_CH | Rising edge seen, no falling edge yet |

## Verification
The edge properties compare each event against the previous cycle's level. They therefore assume that reset is held for at least two clock cycles, so that the past value they read is a reset value. The stimulus holds reset for four cycles at the start and for two cycles when it resets mid-run. The error property assumes that register writes arrive only as strobes sampled at a clock edge. The bench changes every input just after a rising edge and never on the edge itself. The status-window property treats reads as combinational from the current offset, so the bench leaves each offset stable for a full cycle before any comparison.

// File: rtl/rr_pkg.sv
package rr_pkg;

    localparam int DATA_W     = 32;
    localparam int CH_FIELD_W = 5;
    localparam int VLD_BIT    = 7;

    typedef struct packed {
        logic                  vld;
        logic [CH_FIELD_W-1:0] ch;
    } map_ent_t;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_MAP  = 2'd1,
        RGN_STAT = 2'd2
    } rgn_e;

    function automatic map_ent_t ent_from_word(input logic [DATA_W-1:0] w);
        map_ent_t e;
        e.vld = w[VLD_BIT];
        e.ch  = w[CH_FIELD_W-1:0];
        return e;
    endfunction

    function automatic logic [DATA_W-1:0] ent_to_word(input map_ent_t e);
        logic [DATA_W-1:0] w;
        w                   = '0;
        w[VLD_BIT]          = e.vld;
        w[CH_FIELD_W-1:0]   = e.ch;
        return w;
    endfunction

    function automatic logic ch_exists(input logic [CH_FIELD_W-1:0] ch, input int nch);
        return int'({1'b0, ch}) < nch;
    endfunction

endpackage

// File: rtl/rr_addr_dec.sv
module rr_addr_dec
    import rr_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_REQ   = 75,
    parameter int LO_CNT    = 64,
    parameter int LO_BASE   = 32'h100,
    parameter int HI_BASE   = 32'h1100,
    parameter int STAT_BASE = 32'hE0,
    parameter int STAT_CNT  = 3,
    localparam int IDX_W    = $clog2(NUM_REQ)
) (
    input  logic [ADDR_W-1:0] addr,
    output rgn_e              rgn,
    output logic [IDX_W-1:0]  idx
);

    localparam int HI_CNT = NUM_REQ - LO_CNT;

    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_BASE);
    localparam logic [ADDR_W-1:0] LO_E = ADDR_W'(LO_BASE + 4 * LO_CNT);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_BASE);
    localparam logic [ADDR_W-1:0] HI_E = ADDR_W'(HI_BASE + 4 * HI_CNT);
    localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(STAT_BASE);
    localparam logic [ADDR_W-1:0] ST_E = ADDR_W'(STAT_BASE + 4 * STAT_CNT);

    logic [ADDR_W-1:0] lo_off;
    logic [ADDR_W-1:0] hi_off;
    logic              aligned;

    assign lo_off  = addr - LO_A;
    assign hi_off  = addr - HI_A;
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        rgn = RGN_NONE;
        idx = '0;
        if (aligned) begin
            if (addr >= LO_A && addr < LO_E) begin
                rgn = RGN_MAP;
                idx = lo_off[IDX_W+1:2];
            end else if (addr >= HI_A && addr < HI_E) begin
                rgn = RGN_MAP;
                idx = IDX_W'(LO_CNT) + hi_off[IDX_W+1:2];
            end else if (addr >= ST_A && addr < ST_E) begin
                rgn = RGN_STAT;
            end
        end
    end

endmodule

// File: rtl/rr_map_regs.sv
module rr_map_regs
    import rr_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16,
    localparam int IDX_W  = $clog2(NUM_REQ)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          widx,
    input  logic [DATA_W-1:0]         wdata,
    output map_ent_t [NUM_REQ-1:0]    map_q,
    output logic                      err_q
);

    map_ent_t wr_ent;
    logic     wr_ok;

    assign wr_ent = ent_from_word(wdata);
    assign wr_ok  = !wr_ent.vld || ch_exists(wr_ent.ch, NUM_CH);

    always_ff @(posedge clk) begin
        if (rst) begin
            map_q <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= wr_en && !wr_ok;
            for (int r = 0; r < NUM_REQ; r++) begin
                if (wr_en && wr_ok && widx == IDX_W'(r)) begin
                    map_q[r] <= wr_ent;
                end
            end
        end
    end

endmodule

// File: rtl/rr_route_edge.sv
module rr_route_edge
    import rr_pkg::*;
#(
    parameter int NUM_REQ = 75,
    parameter int NUM_CH  = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_REQ-1:0]     req_in,
    input  map_ent_t [NUM_REQ-1:0] map,
    output logic [NUM_CH-1:0]      lvl_q,
    output logic [NUM_CH-1:0]      ras_evt_q,
    output logic [NUM_CH-1:0]      eor_evt_q,
    output logic [NUM_CH-1:0]      ras_pend_q
);

    logic [NUM_REQ-1:0] req_q;
    logic [NUM_CH-1:0]  lvl_d;
    logic [NUM_CH-1:0]  rise;
    logic [NUM_CH-1:0]  fall;

    function automatic logic chan_active(
        input logic [NUM_REQ-1:0]     rq,
        input map_ent_t [NUM_REQ-1:0] m,
        input int                     c
    );
        logic any;
        any = 1'b0;
        for (int r = 0; r < NUM_REQ; r++) begin
            any = any | (rq[r] & m[r].vld & (m[r].ch == CH_FIELD_W'(c)));
        end
        return any;
    endfunction

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
            assign lvl_d[c] = chan_active(req_q, map, c);
        end
    endgenerate

    assign rise = lvl_d & ~lvl_q;
    assign fall = ~lvl_d & lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q      <= '0;
            lvl_q      <= '0;
            ras_evt_q  <= '0;
            eor_evt_q  <= '0;
            ras_pend_q <= '0;
        end else begin
            req_q      <= req_in;
            lvl_q      <= lvl_d;
            ras_evt_q  <= rise;
            eor_evt_q  <= fall;
            ras_pend_q <= (ras_pend_q | rise) & ~fall;
        end
    end

endmodule

// File: rtl/req_router.sv
module req_router
    import rr_pkg::*;
#(
    parameter int NUM_REQ   = 75,
    parameter int NUM_CH    = 16,
    parameter int ADDR_W    = 16,
    parameter int LO_CNT    = 64,
    parameter int LO_BASE   = 32'h100,
    parameter int HI_BASE   = 32'h1100,
    parameter int STAT_BASE = 32'hE0,
    parameter int STAT_CNT  = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_REQ-1:0]   req_in,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 reg_hit,
    output logic                 map_err,
    output logic [NUM_CH-1:0]    ch_req_lvl,
    output logic [NUM_CH-1:0]    ch_ras_evt,
    output logic [NUM_CH-1:0]    ch_eor_evt,
    output logic [NUM_CH-1:0]    ch_ras_pend
);

    localparam int IDX_W = $clog2(NUM_REQ);

    rgn_e                   rgn;
    logic [IDX_W-1:0]       idx;
    map_ent_t [NUM_REQ-1:0] map_q;

    rr_addr_dec #(
        .ADDR_W    (ADDR_W),
        .NUM_REQ   (NUM_REQ),
        .LO_CNT    (LO_CNT),
        .LO_BASE   (LO_BASE),
        .HI_BASE   (HI_BASE),
        .STAT_BASE (STAT_BASE),
        .STAT_CNT  (STAT_CNT)
    ) u_dec (
        .addr (reg_addr),
        .rgn  (rgn),
        .idx  (idx)
    );

    rr_map_regs #(
        .NUM_REQ (NUM_REQ),
        .NUM_CH  (NUM_CH)
    ) u_map (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr && rgn == RGN_MAP),
        .widx  (idx),
        .wdata (reg_wdata),
        .map_q (map_q),
        .err_q (map_err)
    );

    rr_route_edge #(
        .NUM_REQ (NUM_REQ),
        .NUM_CH  (NUM_CH)
    ) u_route (
        .clk        (clk),
        .rst        (rst),
        .req_in     (req_in),
        .map        (map_q),
        .lvl_q      (ch_req_lvl),
        .ras_evt_q  (ch_ras_evt),
        .eor_evt_q  (ch_eor_evt),
        .ras_pend_q (ch_ras_pend)
    );

    assign reg_hit   = (rgn != RGN_NONE);
    assign reg_rdata = (rgn == RGN_MAP) ? ent_to_word(map_q[idx]) : '0;

endmodule

// File: rtl/req_router_chk.sv
module req_router_chk #(
    parameter int NUM_REQ   = 75,
    parameter int NUM_CH    = 16,
    parameter int ADDR_W    = 16,
    parameter int STAT_BASE = 32'hE0,
    parameter int STAT_CNT  = 3
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_REQ-1:0]  req_in,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [31:0]         reg_wdata,
    input logic [31:0]         reg_rdata,
    input logic                reg_hit,
    input logic                map_err,
    input logic [NUM_CH-1:0]   ch_req_lvl,
    input logic [NUM_CH-1:0]   ch_ras_evt,
    input logic [NUM_CH-1:0]   ch_eor_evt,
    input logic [NUM_CH-1:0]   ch_ras_pend
);

    localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(STAT_BASE);
    localparam logic [ADDR_W-1:0] ST_E = ADDR_W'(STAT_BASE + 4 * STAT_CNT);

    logic in_stat;
    assign in_stat = (reg_addr >= ST_A) && (reg_addr < ST_E) && (reg_addr[1:0] == 2'b00);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ch_req_lvl == '0 && ch_ras_pend == '0 && !map_err)); // R1

    AST_STAT_ZERO: assert property (@(posedge clk) disable iff (rst)
        in_stat |-> (reg_hit && reg_rdata == '0)); // R3

    AST_RISE_EDGE: assert property (@(posedge clk) disable iff (rst)
        (ch_ras_evt & ~(ch_req_lvl & ~$past(ch_req_lvl))) == '0); // R6

    AST_FALL_EDGE: assert property (@(posedge clk) disable iff (rst)
        (ch_eor_evt & ~($past(ch_req_lvl) & ~ch_req_lvl)) == '0); // R7

    AST_PEND_HELD: assert property (@(posedge clk) disable iff (rst)
        (ch_ras_pend & ~ch_req_lvl) == '0); // R8

    AST_ERR_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
        map_err |-> $past(reg_wr)); // R9

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !reg_hit |-> reg_rdata == '0); // R10

endmodule

bind req_router req_router_chk #(
    .NUM_REQ   (NUM_REQ),
    .NUM_CH    (NUM_CH),
    .ADDR_W    (ADDR_W),
    .STAT_BASE (STAT_BASE),
    .STAT_CNT  (STAT_CNT)
) u_chk (.*);

// File: tb/req_router_bench.sv
module req_router_bench;

    localparam int NUM_REQ  = 75;
    localparam int NUM_CH   = 16;
    localparam int ADDR_W   = 16;
    localparam int PERIOD   = 10;
    localparam int WD_LIMIT = 20000;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NUM_REQ-1:0]  req_in = '0;
    logic                reg_wr = 1'b0;
    logic [ADDR_W-1:0]   reg_addr = '0;
    logic [31:0]         reg_wdata = '0;
    logic [31:0]         reg_rdata;
    logic                reg_hit;
    logic                map_err;
    logic [NUM_CH-1:0]   ch_req_lvl;
    logic [NUM_CH-1:0]   ch_ras_evt;
    logic [NUM_CH-1:0]   ch_eor_evt;
    logic [NUM_CH-1:0]   ch_ras_pend;

    req_router #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_req_router (
        .clk(clk), .rst(rst), .req_in(req_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_hit(reg_hit), .map_err(map_err),
        .ch_req_lvl(ch_req_lvl), .ch_ras_evt(ch_ras_evt), .ch_eor_evt(ch_eor_evt),
        .ch_ras_pend(ch_ras_pend)
    );

    always #(PERIOD/2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit started = 0;

    // reference model state
    bit                m_vld [NUM_REQ];
    int                m_ch  [NUM_REQ];
    bit                m_rq  [NUM_REQ];
    logic [NUM_CH-1:0] e_lvl, e_ras, e_eor, e_pend;
    logic              e_err;

    function automatic int map_index(input logic [ADDR_W-1:0] a);
        if (a[1:0] != 2'b00) return -1;
        if (a >= 16'h0100 && a < 16'h0200) return int'((a - 16'h0100) >> 2);
        if (a >= 16'h1100 && a < 16'h1100 + 16'(4 * (NUM_REQ - 64)))
            return 64 + int'((a - 16'h1100) >> 2);
        return -1;
    endfunction

    function automatic bit is_status(input logic [ADDR_W-1:0] a);
        return a == 16'h00E0 || a == 16'h00E4 || a == 16'h00E8;
    endfunction

    function automatic logic [ADDR_W-1:0] entry_addr(input int k);
        if (k < 64) return 16'(16'h0100 + 4 * k);
        return 16'(16'h1100 + 4 * (k - 64));
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // model advances on every clock edge
    always @(posedge clk) begin
        logic [NUM_CH-1:0] comb;
        int k;
        started <= 1'b1;
        if (rst) begin
            for (int r = 0; r < NUM_REQ; r++) begin
                m_vld[r] = 0; m_ch[r] = 0; m_rq[r] = 0;
            end
            e_lvl = '0; e_ras = '0; e_eor = '0; e_pend = '0; e_err = 1'b0;
        end else begin
            comb = '0;
            for (int r = 0; r < NUM_REQ; r++)
                if (m_rq[r] && m_vld[r]) comb[m_ch[r]] = 1'b1;
            e_ras  = comb & ~e_lvl;
            e_eor  = ~comb & e_lvl;
            e_pend = (e_pend | e_ras) & ~e_eor;
            e_lvl  = comb;
            e_err  = 1'b0;
            if (reg_wr) begin
                k = map_index(reg_addr);
                if (k >= 0) begin
                    if (reg_wdata[7] && int'(reg_wdata[4:0]) >= NUM_CH) e_err = 1'b1;
                    else begin
                        m_vld[k] = reg_wdata[7];
                        m_ch[k]  = int'(reg_wdata[4:0]);
                    end
                end
            end
            for (int r = 0; r < NUM_REQ; r++) m_rq[r] = req_in[r];
        end
    end

    // compare on the falling edge, away from the active edge
    always @(negedge clk) begin
        int k;
        logic [31:0] exp_rd;
        string rtag;
        if (started) begin
            check("R5 level",   32'(ch_req_lvl),  32'(e_lvl));
            check("R6 rise",    32'(ch_ras_evt),  32'(e_ras));
            check("R7 fall",    32'(ch_eor_evt),  32'(e_eor));
            check("R8 pending", 32'(ch_ras_pend), 32'(e_pend));
            check("R9 error",   32'(map_err),     32'(e_err));
            k = map_index(reg_addr);
            exp_rd = '0;
            if (k >= 0) exp_rd = {24'h0, m_vld[k], 2'b00, 5'(m_ch[k])};
            rtag = (k >= 0) ? "R2" : (is_status(reg_addr) ? "R3" : "R10");
            check({rtag, " rdata"}, reg_rdata, exp_rd);
            check({rtag, " hit"}, 32'(reg_hit), 32'(k >= 0 || is_status(reg_addr)));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual %0d cycles expected below %0d", cycles, WD_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_wr = 1'b0;
        step(1);
    endtask

    initial begin
        logic [15:0] lf;
        step(4);
        rst = 1'b0;
        step(1);
        // R1: everything clear after reset
        check("R1 level after reset", 32'(ch_req_lvl), 32'h0);
        reg_addr = entry_addr(0);
        #1 check("R1 entry after reset", reg_rdata, 32'h0);
        step(1);

        for (int k = 0; k < NUM_REQ; k++) begin
            reg_addr = entry_addr(k);
            step(1);
        end

        wr(entry_addr(3),  32'h0000_0082);   // R2 low window, ch2
        wr(entry_addr(70), 32'hFFFF_FF82);   // R2 high window, upper bits dropped
        wr(entry_addr(10), 32'h0000_0085);
        wr(entry_addr(64), 32'h0000_008F);   // ch15, the top channel
        wr(entry_addr(11), 32'h0000_008F);
        wr(entry_addr(20), 32'h0000_0007);   // R4 disabled entry
        wr(entry_addr(5),  32'h0000_0094);   // R9 refused
        wr(entry_addr(74), 32'h0000_0090);   // R9 boundary, ch16 refused
        wr(16'h00E4, 32'hFFFF_FFFF);         // R3 status write ignored
        reg_addr = 16'h00E4; step(2);
        wr(16'h0200, 32'h0000_0081);         // R10 unmapped
        wr(16'h0101, 32'h0000_0081);         // R10 misaligned
        reg_addr = entry_addr(0);
        #1 check("R10 entry 0 untouched", reg_rdata, 32'h0);
        step(1);
        reg_addr = entry_addr(5); step(1);
        reg_addr = entry_addr(74); step(1);

        req_in[20] = 1'b1; step(3);
        check("R4 disabled input ignored", 32'(ch_req_lvl | ch_ras_evt), 32'h0);
        req_in[3] = 1'b1; step(3);
        req_in[70] = 1'b1; step(2);
        req_in[3] = 1'b0; step(3);
        req_in[70] = 1'b0; step(3);
        req_in[64] = 1'b1; req_in[11] = 1'b1; step(3);
        req_in[64] = 1'b0; step(2);
        req_in[11] = 1'b0; step(2);
        req_in[10] = 1'b1; step(3);
        wr(entry_addr(10), 32'h0000_0086);   // remap while active
        step(2);
        wr(entry_addr(10), 32'h0000_0006);   // disable while active
        step(2);
        req_in[10] = 1'b0; step(1);

        lf = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            req_in[int'(lf) % NUM_REQ] = ~req_in[int'(lf) % NUM_REQ];
            if (i % 8 == 0) begin
                reg_wr    = 1'b1;
                reg_addr  = entry_addr(int'(lf[14:8]) % NUM_REQ);
                reg_wdata = {24'h0, lf[3], 2'b00, lf[7:4], lf[1]};
            end else begin
                reg_wr = 1'b0;
            end
            step(1);
        end
        reg_wr = 1'b0;
        step(2);

        rst = 1'b1; step(2);
        rst = 1'b0; step(1);
        check("R1 level after mid reset", 32'(ch_req_lvl | ch_ras_pend), 32'h0);
        req_in = '0;
        step(4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule